// File: doc/BRIEF.md
# Serial Receiver with Flag-Tagged Character Queue

This block turns an asynchronous serial line into a queue of received characters. It samples the line at sixteen times the bit rate, as paced by a one-cycle oversampling tick from an external divisor. It accepts frames of 5 to 8 data bits, with optional even or odd parity and one or two stop bits. Every character is stored together with its own error tags: framing, parity, overrun and line break. A later reader can therefore tell exactly which character went wrong.

The queue holds 16 entries. Software can also fall back to a single holding register when queuing is turned off. Reading pops the oldest entry and presents a 12-bit word with the character in the low byte and the tags above it.

Three outputs guide the reader:
- an empty flag;
- a level request, raised when the queue is half full (or holds anything, in holding mode);
- an idle-timeout request, which flushes a partly filled queue when the line has gone quiet.

Top module: `uart_rx_tagq`

## Requirements
- R1: The read word `rd_word` carries the character in bits 7:0, framing error at bit 8, parity error at bit 9, overrun at bit 10 and break at bit 11.
- R2: `wlen_code` selects the data length: 00 = 5, 01 = 6, 10 = 7, 11 = 8 bits. Bits are received LSB first, and the data bits above the selected length read as 0.
- R3: With `par_en` = 1, one parity bit follows the data. `par_even` = 1 selects even parity and 0 selects odd. A mismatch sets bit 9.
- R4: `two_stop` = 1 expects two stop bits. A low sample in any expected stop bit sets bit 8.
- R5: A line held low from the start bit through the last stop bit stores a break entry, which reads as 0x900 (break and framing set, character 0x00, parity clear).
- R6: A falling edge is confirmed as a start bit only if the line is still low at the 8th oversampling tick. A shorter low pulse stores nothing.
- R7: With `fifo_en` = 1 the queue holds 16 entries, returned oldest first. With `fifo_en` = 0 it holds one entry.
- R8: A character that completes while the queue is full is discarded, and bit 10 is set on the most recently stored entry. A pop in the same cycle as the completion frees room, so the character is stored and no overrun is marked.
- R9: `rx_empty` is 1 exactly when no entry is held. While it is 1, `rd_word` is 0 and `rd_pop` has no effect.
- R10: `rx_irq` is 1 when the queue holds 8 or more entries with `fifo_en` = 1, or holds any entry with `fifo_en` = 0.
- R11: `rx_tmo_irq` rises when the queue is not empty and 32 bit periods (512 ticks) pass with neither a confirmed start bit nor a pop. It clears on the next pop.
- R12: After reset the queue is empty and both requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling tick, 16 per bit period |
| rx_in | input | 1 | Serial line, idle high |
| fifo_en | input | 1 | 1 = 16-entry queue, 0 = single holding register |
| wlen_code | input | 2 | Data length code |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| two_stop | input | 1 | Two stop bits expected |
| rd_pop | input | 1 | Pop the oldest entry |
| rd_word | output | 12 | Oldest entry: flags and character |
| rx_empty | output | 1 | No entry held |
| rx_irq | output | 1 | Level request |
| rx_tmo_irq | output | 1 | Idle-timeout request |

## Verification
A reader pop and the completion of a new character can land in the same clock cycle. When that happens against a full holding register, the block must decide between storing the character and marking an overrun. The bench provokes this by filling the holding register and then sending a second frame. It repeats the frame while sweeping the pop across the whole stop bit in two-clock steps, so that one offset is bound to coincide with the store. Each outcome is judged at the ports: either the popped word is clean and the new character is waiting, or the popped word carries the overrun tag and the queue is empty afterwards.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    localparam int OSR = 16;

    typedef struct packed {
        logic       brk;
        logic       ovr;
        logic       perr;
        logic       ferr;
        logic [7:0] ch;
    } rxq_entry_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    // index of the last data bit for a length code (5..8 bits)
    function automatic logic [2:0] last_bit_idx(input logic [1:0] code);
        return 3'd4 + {1'b0, code};
    endfunction

    // parity error given the xor of all data and parity bits
    function automatic logic parity_bad(input logic acc, input logic even);
        return acc ^ ~even;
    endfunction

endpackage

// File: rtl/rx_framer.sv
module rx_framer
    import uart_rxq_pkg::*;
#(
    parameter int OVS   = OSR,
    parameter int SYNCN = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rx_in,
    input  logic [1:0] wlen_code,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       two_stop,
    output logic       start_ok,
    output logic       frame_vld,
    output rxq_entry_t frame_out
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    logic [SYNCN-1:0] sync_q;
    logic             rx_s;
    rx_state_e        state;
    logic [CW-1:0]    os_cnt;
    logic [2:0]       bit_idx;
    logic [7:0]       shreg;
    logic             par_acc, all_zero, ferr_q, stop_idx;
    logic             ferr_n, zero_n;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNCN-2:0], rx_in};
    end
    assign rx_s   = sync_q[SYNCN-1];
    assign ferr_n = ferr_q | ~rx_s;
    assign zero_n = all_zero & ~rx_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RX_IDLE;
            os_cnt    <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            par_acc   <= 1'b0;
            all_zero  <= 1'b1;
            ferr_q    <= 1'b0;
            stop_idx  <= 1'b0;
            start_ok  <= 1'b0;
            frame_vld <= 1'b0;
            frame_out <= '0;
        end else begin
            start_ok  <= 1'b0;
            frame_vld <= 1'b0;
            if (tick) begin
                case (state)
                    RX_IDLE: if (!rx_s) begin
                        state  <= RX_START;
                        os_cnt <= '0;
                    end
                    RX_START: begin
                        if (os_cnt == MID) begin
                            if (rx_s) begin
                                state <= RX_IDLE;
                            end else begin
                                state    <= RX_DATA;
                                os_cnt   <= '0;
                                bit_idx  <= '0;
                                shreg    <= '0;
                                par_acc  <= 1'b0;
                                all_zero <= 1'b1;
                                ferr_q   <= 1'b0;
                                stop_idx <= 1'b0;
                                start_ok <= 1'b1;
                            end
                        end else begin
                            os_cnt <= os_cnt + CW'(1);
                        end
                    end
                    default: begin
                        os_cnt <= (os_cnt == LAST) ? '0 : os_cnt + CW'(1);
                        if (os_cnt == LAST) begin
                            case (state)
                                RX_DATA: begin
                                    shreg[bit_idx] <= rx_s;
                                    par_acc        <= par_acc ^ rx_s;
                                    all_zero       <= zero_n;
                                    if (bit_idx == last_bit_idx(wlen_code))
                                        state <= par_en ? RX_PAR : RX_STOP;
                                    else
                                        bit_idx <= bit_idx + 3'd1;
                                end
                                RX_PAR: begin
                                    par_acc  <= par_acc ^ rx_s;
                                    all_zero <= zero_n;
                                    state    <= RX_STOP;
                                end
                                default: begin
                                    if (!two_stop || stop_idx) begin
                                        frame_vld <= 1'b1;
                                        state     <= RX_IDLE;
                                        if (zero_n)
                                            frame_out <= '{brk: 1'b1, ovr: 1'b0, perr: 1'b0,
                                                           ferr: 1'b1, ch: 8'h00};
                                        else
                                            frame_out <= '{brk: 1'b0, ovr: 1'b0,
                                                           perr: par_en & parity_bad(par_acc, par_even),
                                                           ferr: ferr_n, ch: shreg};
                                    end else begin
                                        stop_idx <= 1'b1;
                                        ferr_q   <= ferr_n;
                                        all_zero <= zero_n;
                                    end
                                end
                            endcase
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/rx_tagq.sv
module rx_tagq
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int IRQ_LVL = DEPTH / 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fifo_en,
    input  logic               push,
    input  rxq_entry_t         push_data,
    input  logic               pop,
    output rxq_entry_t         head,
    output logic               empty,
    output logic               irq,
    output logic [$clog2(DEPTH):0] level
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    rxq_entry_t    mem [DEPTH];
    logic [AW-1:0] rptr, wptr;
    logic [LW-1:0] count, cap;
    logic          full, do_pop, do_push, ovr_mark;

    assign cap      = fifo_en ? LW'(DEPTH) : LW'(1);
    assign full     = count >= cap;
    assign empty    = (count == '0);
    assign do_pop   = pop & ~empty;
    assign do_push  = push & (~full | do_pop);
    assign ovr_mark = push & full & ~do_pop & ~empty;

    always_ff @(posedge clk) begin
        if (do_push)  mem[wptr] <= push_data;
        if (ovr_mark) mem[wptr - AW'(1)].ovr <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr  <= '0;
            wptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + AW'(1);
            if (do_pop)  rptr <= rptr + AW'(1);
            count <= count + LW'(do_push) - LW'(do_pop);
        end
    end

    assign head  = empty ? '0 : mem[rptr];
    assign irq   = fifo_en ? (count >= LW'(IRQ_LVL)) : ~empty;
    assign level = count;
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
    parameter int LIMIT = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic active,
    input  logic start_seen,
    input  logic pop,
    output logic tmo
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !active || pop) begin
            cnt <= '0;
            tmo <= 1'b0;
        end else if (start_seen) begin
            cnt <= '0;
        end else if (tick && cnt != CW'(LIMIT)) begin
            cnt <= cnt + CW'(1);
            if (cnt == CW'(LIMIT - 1)) tmo <= 1'b1;
        end
    end
endmodule

// File: rtl/uart_rx_tagq.sv
module uart_rx_tagq
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int IDLE_BITS = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        os_tick,
    input  logic        rx_in,
    input  logic        fifo_en,
    input  logic [1:0]  wlen_code,
    input  logic        par_en,
    input  logic        par_even,
    input  logic        two_stop,
    input  logic        rd_pop,
    output logic [11:0] rd_word,
    output logic        rx_empty,
    output logic        rx_irq,
    output logic        rx_tmo_irq
);
    localparam int LW = $clog2(DEPTH) + 1;

    logic          start_ok, frame_vld;
    rxq_entry_t    frame_out, head;
    logic [LW-1:0] q_level;

    rx_framer #(.OVS(OSR), .SYNCN(2)) u_fr (
        .clk(clk), .rst(rst), .tick(os_tick), .rx_in(rx_in),
        .wlen_code(wlen_code), .par_en(par_en), .par_even(par_even),
        .two_stop(two_stop), .start_ok(start_ok), .frame_vld(frame_vld),
        .frame_out(frame_out)
    );

    rx_tagq #(.DEPTH(DEPTH), .IRQ_LVL(DEPTH / 2)) u_q (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .push(frame_vld),
        .push_data(frame_out), .pop(rd_pop), .head(head), .empty(rx_empty),
        .irq(rx_irq), .level(q_level)
    );

    rx_idle_timer #(.LIMIT(IDLE_BITS * OSR)) u_tmr (
        .clk(clk), .rst(rst), .tick(os_tick), .active(~rx_empty),
        .start_seen(start_ok), .pop(rd_pop), .tmo(rx_tmo_irq)
    );

    assign rd_word = head;
endmodule

// File: rtl/uart_rx_tagq_chk.sv
module uart_rx_tagq_chk #(
    parameter int DEPTH = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    rd_pop,
    input logic [11:0]             rd_word,
    input logic                    rx_empty,
    input logic                    rx_irq,
    input logic                    rx_tmo_irq,
    input logic                    q_push,
    input logic [$clog2(DEPTH):0]  q_level
);
    // R9
    empty_word_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rx_empty |-> rd_word == 12'h000);
    // R9
    pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
        rx_empty && !q_push |=> rx_empty);
    // R10
    irq_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> !rx_empty);
    // R11
    tmo_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
        rx_tmo_irq |-> !rx_empty);
    // R11
    tmo_clear_chk: assert property (@(posedge clk) disable iff (rst)
        rd_pop && !rx_empty |=> !rx_tmo_irq);
    // R5
    break_word_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_empty && rd_word[11] |-> rd_word[8] && !rd_word[9] && rd_word[7:0] == 8'h00);
    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        q_level <= ($clog2(DEPTH) + 1)'(DEPTH));
endmodule

bind uart_rx_tagq uart_rx_tagq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .rd_pop(rd_pop), .rd_word(rd_word),
    .rx_empty(rx_empty), .rx_irq(rx_irq), .rx_tmo_irq(rx_tmo_irq),
    .q_push(frame_vld), .q_level(q_level)
);

// File: tb/tb_uart_rx_tagq.sv
`timescale 1ns/1ps
module tb_uart_rx_tagq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        os_tick = 1'b0;
    logic        rx_in = 1'b1;
    logic        fifo_en = 1'b1;
    logic [1:0]  wlen_code = 2'd3;
    logic        par_en = 1'b0, par_even = 1'b0, two_stop = 1'b0;
    logic        rd_pop = 1'b0;
    logic [11:0] rd_word;
    logic        rx_empty, rx_irq, rx_tmo_irq;

    int n_run = 0, n_fail = 0;
    logic [1:0] tdiv = '0;
    bit done = 0;

    uart_rx_tagq dut (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rx_in(rx_in), .fifo_en(fifo_en),
        .wlen_code(wlen_code), .par_en(par_en), .par_even(par_even),
        .two_stop(two_stop), .rd_pop(rd_pop), .rd_word(rd_word),
        .rx_empty(rx_empty), .rx_irq(rx_irq), .rx_tmo_irq(rx_tmo_irq)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        tdiv    <= tdiv + 2'd1;
        os_tick <= (tdiv == 2'd3);
    end

    typedef struct packed {
        logic [1:0]  wl;
        logic        pe, pev, ts, badp, bads;
        logic [7:0]  data;
        logic [11:0] exp;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 12'h0A5},
        '{2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h13, 12'h013},
        '{2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h55, 12'h055},
        '{2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h3C, 12'h23C},
        '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h2A, 12'h12A},
        '{2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 12'h0FF},
        '{2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hF7, 12'h017}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n) begin
            @(posedge clk);
            while (!os_tick) @(posedge clk);
        end
    endtask

    task automatic drive(input logic v, input int n);
        @(negedge clk);
        rx_in = v;
        wait_ticks(n);
    endtask

    task automatic send(input logic [7:0] d, input logic badp, input logic bads);
        int nb;
        logic p;
        nb = 5 + int'(wlen_code);
        p  = 1'b0;
        drive(1'b0, 16);
        for (int i = 0; i < nb; i++) begin
            drive(d[i], 16);
            p = p ^ d[i];
        end
        if (par_en) drive(p ^ ~par_even ^ badp, 16);
        if (bads) begin
            drive(1'b0, 12);
            drive(1'b1, 4);
        end else begin
            drive(1'b1, 16);
        end
        if (two_stop) drive(1'b1, 16);
        drive(1'b1, 8);
    endtask

    task automatic pop_expect(input logic [11:0] exp, input string req);
        @(negedge clk);
        check(!rx_empty, {req, " not empty"}, rx_empty, 0);
        check(rd_word == exp, req, rd_word, exp);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int seen_clean, seen_ovr;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check(rx_empty == 1'b1, "R12 empty", rx_empty, 1);
        check(rx_irq == 1'b0, "R12 irq", rx_irq, 0);
        check(rx_tmo_irq == 1'b0, "R12 tmo", rx_tmo_irq, 0);
        check(rd_word == 12'h000, "R9 word when empty", rd_word, 0);

        // R1 R2 R3 R4 vector table
        for (int v = 0; v < NV; v++) begin
            wlen_code = VEC[v].wl;
            par_en    = VEC[v].pe;
            par_even  = VEC[v].pev;
            two_stop  = VEC[v].ts;
            send(VEC[v].data, VEC[v].badp, VEC[v].bads);
            pop_expect(VEC[v].exp, "R1 R2 R3 R4 vector");
            @(negedge clk);
            check(rx_empty, "R9 empty after pop", rx_empty, 1);
        end
        wlen_code = 2'd3; par_en = 1'b0; par_even = 1'b0; two_stop = 1'b0;

        // R9 pop on empty has no effect
        @(negedge clk); rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0;
        check(rx_empty && rd_word == 0, "R9 pop on empty", rd_word, 0);
        send(8'h6E, 1'b0, 1'b0);
        pop_expect(12'h06E, "R9 after empty pop");

        // R5 break
        drive(1'b0, 156);
        drive(1'b1, 32);
        pop_expect(12'h900, "R5 break");

        // R6 false start
        drive(1'b0, 4);
        drive(1'b1, 32);
        check(rx_empty, "R6 false start", rx_empty, 1);

        // R10 threshold and R7 ordering
        for (int i = 0; i < 7; i++) send(8'h10 + 8'(i), 1'b0, 1'b0);
        check(rx_irq == 1'b0, "R10 seven held", rx_irq, 0);
        send(8'h17, 1'b0, 1'b0);
        check(rx_irq == 1'b1, "R10 eight held", rx_irq, 1);
        for (int i = 0; i < 8; i++) pop_expect(12'h010 + 12'(i), "R7 order");

        // R8 overrun in queue mode
        for (int i = 0; i < 17; i++) send(8'h40 + 8'(i), 1'b0, 1'b0);
        for (int i = 0; i < 15; i++) pop_expect(12'h040 + 12'(i), "R7 depth");
        pop_expect(12'h44F, "R8 overrun tag on newest");
        @(negedge clk);
        check(rx_empty, "R8 new char discarded", rx_empty, 1);

        // R7 R10 holding mode
        fifo_en = 1'b0;
        send(8'h21, 1'b0, 1'b0);
        check(rx_irq == 1'b1, "R10 holding irq", rx_irq, 1);
        send(8'h22, 1'b0, 1'b0);
        pop_expect(12'h421, "R8 holding overrun");
        @(negedge clk);
        check(rx_empty, "R7 holding single", rx_empty, 1);

        // R11 timeout
        fifo_en = 1'b1;
        send(8'h33, 1'b0, 1'b0);
        wait_ticks(15 * 16);
        @(negedge clk);
        check(rx_tmo_irq == 1'b0, "R11 early", rx_tmo_irq, 0);
        wait_ticks(25 * 16);
        @(negedge clk);
        check(rx_tmo_irq == 1'b1, "R11 raised", rx_tmo_irq, 1);
        pop_expect(12'h033, "R11 data");
        check(rx_tmo_irq == 1'b0, "R11 cleared by pop", rx_tmo_irq, 0);

        // R8 pop coinciding with arrival, swept across the stop bit
        fifo_en = 1'b0;
        seen_clean = 0;
        seen_ovr = 0;
        for (int off = 0; off < 64; off += 2) begin
            logic [11:0] got;
            send(8'h11, 1'b0, 1'b0);
            fork
                send(8'h5A, 1'b0, 1'b0);
                begin
                    @(negedge clk);
                    wait_ticks(9 * 16);
                    repeat (off) @(posedge clk);
                    @(negedge clk);
                    got = rd_word;
                    rd_pop = 1'b1;
                    @(negedge clk);
                    rd_pop = 1'b0;
                end
            join
            @(negedge clk);
            if (got == 12'h011) begin
                seen_clean++;
                check(!rx_empty && rd_word == 12'h05A, "R8 pop same cycle stores", rd_word, 12'h05A);
                rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0;
            end else begin
                seen_ovr++;
                check(got == 12'h411 && rx_empty, "R8 late pop sees overrun", got, 12'h411);
            end
        end
        check(seen_clean > 0 && seen_ovr > 0, "R8 sweep covers both", seen_clean, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule